// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block is the digital counter chain of one fractional-N frequency synthesizer loop. It runs on the output clock of a dual-modulus prescaler, one clock edge per prescaler cycle, and drives that prescaler's modulus-select line: high asks for a divide by P+1, low for a divide by P. Each output period lasts M prescaler cycles. The first S of them are P+1 cycles, where S is the swallow value A plus one when a 5-bit fractional accumulator overflows. The accumulator adds the numerator F once per period. Over time this gives an average VCO-to-output division ratio of P·M + A + F/32. One divided pulse marks the last prescaler cycle of every period. The phase detector compares that pulse with the reference divider output.

The prescaler modulus P is a parameter, 32 for a high-band loop or 16 for a low-band loop, and it sets the swallow-field width. Software programs M, A and F. A synchronous counter clear realigns the chain with the reference divider. A power-down input stops the chain. For contiguous channel coverage the programmed total P·M + A should be at least 1024 with P = 32, or at least 256 with P = 16. The block does not enforce this; it is a rule for the programmer.

Top module: `fracn_divider`

## Requirements
- R1: `mod_hi` = 1 requests P+1 and 0 requests P. Within a period `mod_hi` is high for exactly the first S cycles and then low until the period ends, with S = A + carry.
- R2: `div_pulse` is high for exactly one cycle per period, the last of its M cycles, so consecutive pulses are M cycles apart.
- R3: The accumulator is 5 bits wide, modulo 32. At the start of each period it adds F, and its carry adds one P+1 cycle to that period. Counting periods k = 1, 2, ... from a cleared accumulator, period k has the extra cycle exactly when ((k-1)·F mod 32) + F ≥ 32. Its VCO count is then P·M + A + extra.
- R4: Over 32 consecutive periods that start from a cleared accumulator, the VCO count totals 32·(P·M + A) + F, which is an average of P·M + A + F/32.
- R5: `m_val`, `a_val` and `f_val` are sampled only at a period boundary. A change in the middle of a period leaves that period's length and swallow count unchanged, and the next period uses the new values.
- R6: While `cnt_clr` is high, both outputs are low and the accumulator is cleared. The first period starts in the first cycle after the clock edge at which `cnt_clr` is seen low.
- R7: From the cycle after `pwr_dn` is seen high, both outputs stay low. The partial period is abandoned but the accumulator keeps its value. The first period after release therefore carries the accumulator phase reached before power-down.
- R8: `rst` is synchronous and active high. It forces both outputs low, clears the accumulator and leaves a fresh period pending.
- R9: An even F acts as a reduced fraction. F = 16 adds the extra cycle every second period and F = 8 every fourth. F = 0 never adds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per prescaler cycle |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Stops the chain and holds the outputs low |
| cnt_clr | input | 1 | Synchronous counter clear for realignment |
| m_val | input | M_W (9) | Main count M, at least 1 |
| a_val | input | 5 (P=32) / 4 (P=16) | Swallow count A, below M |
| f_val | input | 5 | Fractional numerator F |
| mod_hi | output | 1 | Modulus select: 1 = P+1, 0 = P |
| div_pulse | output | 1 | Divided output, high on the last cycle of a period |

## Verification
The bench measures every period's length, its run of P+1 cycles and its VCO count, and sums the count over 32 periods for numerators of 0, 1, 8, 16 and 31. An off-by-one accumulator width or a misplaced carry would show up as a wrong total or a shifted pattern of extra cycles. One test changes the programmed values mid-period. A design that loaded them at once would shorten or stretch that period. Clear and power-down are each applied mid-period with F = 16. A design that cleared the phase on power-down, or kept it through a clear, would put the extra cycle in the wrong period after release. The case A = M−1 with a carry drives the modulus high for a whole period; there, a swallow counter that wrapped would drop the extra cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // numerator width and modulus of the fractional accumulator
  localparam int FRAC_W   = 5;
  localparam int FRAC_MOD = 1 << FRAC_W;

  // chain state: waiting for a fresh period, or inside one
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } chain_t;
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int F_W = fracn_pkg::FRAC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic [F_W-1:0] f_in,
  output logic           carry,
  output logic [F_W-1:0] phase
);
  logic [F_W:0] sum;

  assign sum   = {1'b0, phase} + {1'b0, f_in};
  assign carry = sum[F_W];

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (step)  phase <= sum[F_W-1:0];
  end

  // R6: a clear leaves the phase at zero on the following cycle
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));

  // R3: the phase moves only at a period start
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(phase));
endmodule

// File: rtl/fracn_seq.sv
module fracn_seq #(
  parameter int M_W = 9,
  parameter int S_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           step,
  input  logic [M_W-1:0] m_in,
  input  logic [S_W-1:0] sw_in,
  output logic           mod_hi,
  output logic           last,
  output logic           fresh
);
  import fracn_pkg::*;

  localparam int CW = (M_W > S_W) ? M_W : S_W;
  localparam logic [M_W-1:0] ONE_M = M_W'(1);

  chain_t         st_q;
  logic [M_W-1:0] pos_q, pos_nx, m_cur;
  logic [S_W-1:0] sw_cur;
  logic [CW-1:0]  pos_x, sw_x;

  assign pos_nx = pos_q + ONE_M;
  assign pos_x  = CW'(pos_nx);
  assign sw_x   = CW'(sw_cur);
  assign fresh  = (st_q == CH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CH_IDLE;
      pos_q  <= '0;
      m_cur  <= '0;
      sw_cur <= '0;
      mod_hi <= 1'b0;
      last   <= 1'b0;
    end else if (!run) begin
      st_q   <= CH_IDLE;
      pos_q  <= '0;
      mod_hi <= 1'b0;
      last   <= 1'b0;
    end else if (step) begin
      st_q   <= CH_RUN;
      pos_q  <= '0;
      m_cur  <= m_in;
      sw_cur <= sw_in;
      mod_hi <= (sw_in != '0);
      last   <= (m_in == ONE_M);
    end else begin
      pos_q  <= pos_nx;
      mod_hi <= (pos_x < sw_x);
      last   <= (pos_nx == m_cur - ONE_M);
    end
  end

  // R7: a stopped chain drives both outputs low
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!mod_hi && !last));

  // R1: once the modulus drops inside a period it stays low
  a_r1_low_stays: assert property (@(posedge clk) disable iff (rst)
    (run && st_q == CH_RUN && !mod_hi && !last) |=> !mod_hi);

  // R2: the cycle after the divided pulse opens a new count
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    last |=> (pos_q == '0));

  // R5: the active main count changes only at a boundary
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(m_cur));
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider #(
  parameter int  PRESCALE = 32,
  parameter int  M_W      = 9,
  localparam int A_W      = (PRESCALE == 32) ? 5 : 4,
  localparam int F_W      = fracn_pkg::FRAC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_dn,
  input  logic           cnt_clr,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic [F_W-1:0] f_val,
  output logic           mod_hi,
  output logic           div_pulse
);
  localparam int S_W = A_W + 1;

  logic           run, step, fresh, carry;
  logic [F_W-1:0] phase;
  logic [S_W-1:0] sw_next;

  assign run     = !pwr_dn && !cnt_clr;
  assign step    = run && (fresh || div_pulse);
  assign sw_next = {1'b0, a_val} + {{A_W{1'b0}}, carry};

  fracn_accum #(.F_W(F_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .step  (step),
    .f_in  (f_val),
    .carry (carry),
    .phase (phase)
  );

  fracn_seq #(.M_W(M_W), .S_W(S_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .step   (step),
    .m_in   (m_val),
    .sw_in  (sw_next),
    .mod_hi (mod_hi),
    .last   (div_pulse),
    .fresh  (fresh)
  );

  // R8: after reset both outputs are low
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mod_hi && !div_pulse));
endmodule

// File: tb/fracn_divider_test.sv
`timescale 1ns/1ps
module fracn_divider_test;
  localparam int P = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       cnt_clr = 1'b0;
  logic [8:0] m_val = 9'd34;
  logic [4:0] a_val = 5'd0;
  logic [4:0] f_val = 5'd0;
  logic       mod_hi, div_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // vectors: M, A, F
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{34, 0, 0}, '{33, 5, 1}, '{40, 31, 16},
    '{35, 7, 31}, '{33, 12, 8}, '{3, 2, 31}
  };

  always #4 clk = ~clk;

  fracn_divider #(.PRESCALE(P), .M_W(9)) uut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .cnt_clr(cnt_clr),
    .m_val(m_val), .a_val(a_val), .f_val(f_val),
    .mod_hi(mod_hi), .div_pulse(div_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // measures one period from its first cycle; optional reprogram mid-way
  task automatic check_period(input int m, input int a, input int extra,
                              input int chg_at, input int nm, input int na, input int nf,
                              input string tag, output int vco);
    int cyc = 0;
    int nhi = 0;
    bit seen_low = 1'b0;
    bit order_ok = 1'b1;
    bit got = 1'b0;
    vco = 0;
    while (!got && cyc < 1000) begin
      @(negedge clk);
      vco += mod_hi ? P + 1 : P;
      if (mod_hi) begin
        nhi++;
        if (seen_low) order_ok = 1'b0;
      end else seen_low = 1'b1;
      if (div_pulse) got = 1'b1;
      if (cyc == chg_at) begin
        m_val = 9'(nm); a_val = 5'(na); f_val = 5'(nf);
      end
      cyc++;
    end
    chk(cyc == m, "R2 period length", cyc, m);
    chk(order_ok && nhi == a + extra, "R1 modulus-high run", nhi, a + extra);
    chk(vco == P * m + a + extra, tag, vco, P * m + a + extra);
  endtask

  task automatic clear_chain();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk);
    chk(!mod_hi && !div_pulse, "R6 outputs low in clear", {mod_hi, div_pulse}, 0);
    cnt_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int v;
    // reset state
    repeat (3) @(negedge clk);
    chk(!mod_hi && !div_pulse, "R8 reset outputs", {mod_hi, div_pulse}, 0);
    @(negedge clk); rst = 1'b0;

    // table walk: 32 periods per vector from a cleared accumulator
    foreach (VEC[i]) begin
      int m, a, f, tot;
      m = VEC[i][0]; a = VEC[i][1]; f = VEC[i][2];
      m_val = 9'(m); a_val = 5'(a); f_val = 5'(f);
      clear_chain();
      tot = 0;
      for (int k = 1; k <= 32; k++) begin
        int extra;
        extra = ((((k - 1) * f) % 32) + f >= 32) ? 1 : 0;
        check_period(m, a, extra, -1, 0, 0, 0,
                     ((f % 2 == 0)) ? "R9 VCO count" : "R3 VCO count", v);
        tot += v;
      end
      chk(tot == 32 * (P * m + a) + f, "R4 32-period total", tot, 32 * (P * m + a) + f);
    end

    // R5: reprogram in mid period
    m_val = 9'd34; a_val = 5'd3; f_val = 5'd0;
    clear_chain();
    check_period(34, 3, 0, 10, 36, 5, 0, "R5 old values hold", v);
    check_period(36, 5, 0, -1, 0, 0, 0, "R5 new values used", v);

    // R7: power-down keeps accumulator phase (F=16, stop in period 1)
    m_val = 9'd34; a_val = 5'd2; f_val = 5'd16;
    clear_chain();
    repeat (5) @(negedge clk);
    pwr_dn = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(!mod_hi && !div_pulse, "R7 outputs low in power-down", {mod_hi, div_pulse}, 0);
    end
    pwr_dn = 1'b0;
    check_period(34, 2, 1, -1, 0, 0, 0, "R7 phase kept", v);

    // R6: clear in period 1 discards phase
    clear_chain();
    repeat (5) @(negedge clk);
    clear_chain();
    check_period(34, 2, 0, -1, 0, 0, 0, "R6 phase cleared", v);

    // R8: reset in mid period, then restart from zero phase
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mod_hi && !div_pulse, "R8 reset mid-period", {mod_hi, div_pulse}, 0);
    rst = 1'b0;
    check_period(34, 2, 0, -1, 0, 0, 0, "R8 first period after reset", v);
    check_period(34, 2, 1, -1, 0, 0, 0, "R8 second period after reset", v);

    finish_run();
  end
endmodule